// File: doc/BRIEF.md
# Serial Control Shift Register with Diagnostic Readback

This block is the serial front end of an eight-channel low-side output controller. A host frames a transfer by pulling a chip-select line low, clocks eight control bits in while the block clocks eight diagnostic bits out, and then releases chip select. At the start of every frame the block captures the live level of each output pin into its shift register. Each reply therefore shows the pin levels seen when the frame opened, not an echo of the last command.

All serial pins are brought into one system clock through two-flop synchronisers, and their edges are found in that clock domain. The system clock must run at least four times faster than the serial clock. When chip select is released, the received byte goes to the output stage on a control bus, together with a one-cycle update strobe. The serial data output comes with a separate drive-enable signal so the pad can float while the block is not selected. Since every bit received in a frame moves on through the serial output, several blocks can be chained on one select line.

Top module: `spi_diag_shifter`

## Requirements
- R1: While reset is high, and after it is released, the control bus reads all ones (every channel off), the update strobe is low and the serial-out enable is low.
- R2: When chip select goes low, the register loads the sense inputs. Sense bit i is 1 when output pin i is high. The frame's first serial-out bit is sense bit 7, and the rest follow down to bit 0.
- R3: The serial clock idles low. The serial output changes after each serial-clock rising edge, and the serial input is captured on each falling edge. The first captured bit becomes control bit 7.
- R4: When chip select goes high, the control bus takes the register contents on the third system-clock edge after the change, and the update strobe is high for exactly that one cycle. A control bit of 0 turns its channel on and 1 turns it off.
- R5: The serial-out enable is high only while the synchronised chip select is low.
- R6: While chip select is high, serial clock and serial data activity changes neither the control bus, the serial output nor the update strobe.
- R7: A frame with a number of serial-clock cycles other than eight still transfers the current register contents when chip select rises. With k bits, the result is the sense byte shifted left by k with the received bits appended.
- R8: When more than eight bits are clocked in one frame, serial-out bit 8+j repeats the serial-in bit j from the same frame, so the block can be chained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| mosi_i | input | 1 | Serial data from the host, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sense_i | input | 8 | Per-channel output level, 1 = pin high |
| miso_o | output | 1 | Serial data to the host |
| miso_oe_o | output | 1 | Drive enable for the serial data pad |
| ctrl_o | output | 8 | Control byte to the output stage, 0 = channel on |
| ctrl_upd_o | output | 1 | One-cycle strobe marking a new control byte |

## Verification
Some properties are checked by assertions on every cycle: the update strobe lasts one cycle and only fires while deselected, and the control bus changes only together with that strobe. The serial output also stays still from one cycle to the next whenever the block was deselected. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the sense-bit capture order, the MSB-first assembly of the control byte, short frames and the pass-through of bits in a sixteen-bit chained frame.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;

    // Serial pins as seen after synchronisation
    typedef struct packed {
        logic csn;
        logic sck;
        logic mosi;
    } spi_pins_t;

    // Idle state of the pins: deselected, clock low
    localparam spi_pins_t PINS_IDLE = '{csn: 1'b1, sck: 1'b0, mosi: 1'b0};

    // Events derived in the system clock domain
    typedef struct packed {
        logic sel_fall;
        logic sel_rise;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } spi_evt_t;

    function automatic logic [7:0] shift_msb_first(input logic [7:0] cur, input logic bit_in);
        return {cur[6:0], bit_in};
    endfunction

endpackage

// File: rtl/spi_diag_sync.sv
module spi_diag_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= RST_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_diag_edges.sv
module spi_diag_edges
    import spi_diag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  spi_pins_t pins_i,
    output spi_evt_t  evt_o,
    output logic      sel_o
);
    spi_pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= PINS_IDLE;
        else     prev <= pins_i;
    end

    always_comb begin
        evt_o.sel_fall = prev.csn & ~pins_i.csn;
        evt_o.sel_rise = ~prev.csn & pins_i.csn;
        evt_o.sck_rise = ~pins_i.csn & pins_i.sck & ~prev.sck;
        evt_o.sck_fall = ~pins_i.csn & ~pins_i.sck & prev.sck;
        evt_o.mosi     = pins_i.mosi;
    end

    assign sel_o = ~pins_i.csn;
endmodule

// File: rtl/spi_diag_sreg.sv
module spi_diag_sreg
    import spi_diag_pkg::*;
#(
    parameter int CHAN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  spi_evt_t        evt_i,
    input  logic [CHAN-1:0] sense_i,
    output logic [CHAN-1:0] sreg_o,
    output logic            sout_o
);
    localparam int MSB = CHAN - 1;

    logic [CHAN-1:0] sreg;
    logic            sout;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '1;
            sout <= 1'b1;
        end else if (evt_i.sel_fall) begin
            sreg <= sense_i;
            sout <= sense_i[MSB];
        end else begin
            if (evt_i.sck_fall) sreg <= {sreg[MSB-1:0], evt_i.mosi};
            if (evt_i.sck_rise) sout <= sreg[MSB];
        end
    end

    assign sreg_o = sreg;
    assign sout_o = sout;
endmodule

// File: rtl/spi_diag_shifter.sv
module spi_diag_shifter
    import spi_diag_pkg::*;
#(
    parameter int CHAN = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sck_i,
    input  logic            mosi_i,
    input  logic            csn_i,
    input  logic [CHAN-1:0] sense_i,
    output logic            miso_o,
    output logic            miso_oe_o,
    output logic [CHAN-1:0] ctrl_o,
    output logic            ctrl_upd_o
);
    localparam int PW = $bits(spi_pins_t);

    spi_pins_t       raw, synced;
    spi_evt_t        evt;
    logic            sel;
    logic [CHAN-1:0] sreg;
    logic [CHAN-1:0] ctrl_q;
    logic            upd_q;

    assign raw = '{csn: csn_i, sck: sck_i, mosi: mosi_i};

    spi_diag_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d_i(raw), .q_o(synced)
    );

    spi_diag_edges u_edges (
        .clk(clk), .rst(rst), .pins_i(synced), .evt_o(evt), .sel_o(sel)
    );

    spi_diag_sreg #(.CHAN(CHAN)) u_sreg (
        .clk(clk), .rst(rst), .evt_i(evt), .sense_i(sense_i),
        .sreg_o(sreg), .sout_o(miso_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '1;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= evt.sel_rise;
            if (evt.sel_rise) ctrl_q <= sreg;
        end
    end

    assign ctrl_o     = ctrl_q;
    assign ctrl_upd_o = upd_q;
    assign miso_oe_o  = sel;
endmodule

// File: rtl/spi_diag_chk.sv
module spi_diag_chk #(
    parameter int CHAN = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            miso_o,
    input logic            miso_oe_o,
    input logic [CHAN-1:0] ctrl_o,
    input logic            ctrl_upd_o
);
    // R4
    upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_upd_o |=> !ctrl_upd_o);

    // R5
    upd_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_upd_o |-> !miso_oe_o);

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_o) |-> ctrl_upd_o);

    // R6
    miso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(miso_oe_o) |-> $stable(miso_o));
endmodule

bind spi_diag_shifter spi_diag_chk #(.CHAN(CHAN)) u_chk (
    .clk(clk), .rst(rst), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .ctrl_o(ctrl_o), .ctrl_upd_o(ctrl_upd_o)
);

// File: tb/sim_spi_diag_shifter.sv
`timescale 1ns/1ps
module sim_spi_diag_shifter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0, mosi = 1'b0, csn = 1'b1;
    logic [7:0] sense = 8'h00;
    logic       miso, miso_oe, upd;
    logic [7:0] ctrl;

    int total = 0, bad = 0, cyc = 0, upd_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_diag_shifter u0 (
        .clk(clk), .rst(rst), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
        .sense_i(sense), .miso_o(miso), .miso_oe_o(miso_oe),
        .ctrl_o(ctrl), .ctrl_upd_o(upd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: input history, newest first
    logic h_cs[$], h_sck[$], h_mosi[$];
    logic [7:0] m_reg, m_ctrl;
    logic m_out, m_upd, m_oe;

    always @(posedge clk) begin
        if (rst) begin
            h_cs = {1'b1, 1'b1, 1'b1};
            h_sck = {1'b0, 1'b0, 1'b0};
            h_mosi = {1'b0, 1'b0, 1'b0};
            m_reg = 8'hFF; m_ctrl = 8'hFF; m_out = 1'b1; m_upd = 1'b0;
        end else begin
            // h[1] is what the block sees now, h[2] one cycle earlier
            m_upd = 1'b0;
            if (h_cs[2] && !h_cs[1]) begin
                m_reg = sense; m_out = sense[7];
            end else if (!h_cs[2] && h_cs[1]) begin
                m_ctrl = m_reg; m_upd = 1'b1;
            end else if (!h_cs[1]) begin
                if (h_sck[2] && !h_sck[1]) m_reg = {m_reg[6:0], h_mosi[1]};
                if (!h_sck[2] && h_sck[1]) m_out = m_reg[7];
            end
            h_cs.push_front(csn); h_sck.push_front(sck); h_mosi.push_front(mosi);
            void'(h_cs.pop_back()); void'(h_sck.pop_back()); void'(h_mosi.pop_back());
        end
        m_oe = !h_cs[1];
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            check("R5 oe", miso_oe, m_oe);
            check("R4 ctrl", ctrl, m_ctrl);
            check("R4 upd", upd, m_upd);
            if (miso_oe) check("R3 miso", miso, m_out);
            if (upd) upd_seen++;
        end
        if (cyc > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic select();
        csn = 1'b0; wait_clk(6);
    endtask

    task automatic deselect();
        csn = 1'b1; wait_clk(6);
    endtask

    // One serial bit: host changes data on the rising edge, samples before falling
    task automatic xfer_bit(input logic b, output logic rx);
        sck = 1'b1; mosi = b; wait_clk(4);
        rx = miso;
        sck = 1'b0; wait_clk(4);
    endtask

    initial begin : main
        logic [15:0] rx;
        logic r;
        wait_clk(4);
        // R1: state during reset
        check("R1 ctrl in reset", ctrl, 8'hFF);
        check("R1 upd in reset", upd, 1'b0);
        check("R1 oe in reset", miso_oe, 1'b0);
        rst = 1'b0; wait_clk(4);
        check("R1 ctrl after reset", ctrl, 8'hFF);

        // R2 R3 R4: one byte with a sense pattern
        sense = 8'hA5; upd_seen = 0;
        select();
        check("R5 oe while selected", miso_oe, 1'b1);
        check("R2 first bit before clock", miso, 1'b1);
        for (int i = 7; i >= 0; i--) begin xfer_bit(8'h3C >> i, r); rx[i] = r; end
        check("R2 readback of sense", rx[7:0], 8'hA5);
        deselect();
        check("R3 R4 ctrl takes byte", ctrl, 8'h3C);
        check("R4 single strobe", upd_seen, 1);
        check("R5 oe after deselect", miso_oe, 1'b0);

        // R6: activity while deselected
        upd_seen = 0;
        for (int i = 0; i < 8; i++) xfer_bit(i[0], r);
        check("R6 ctrl unchanged", ctrl, 8'h3C);
        check("R6 no strobe", upd_seen, 0);

        // R7: short frame of three bits
        sense = 8'h0F;
        select();
        xfer_bit(1'b1, r); xfer_bit(1'b0, r); xfer_bit(1'b1, r);
        deselect();
        check("R7 short frame", ctrl, 8'h7D);

        // R8: chained sixteen-bit frame
        sense = 8'h00;
        select();
        for (int i = 15; i >= 0; i--) begin xfer_bit(16'h965A >> i, r); rx[i] = r; end
        deselect();
        check("R8 first byte is sense", rx[15:8], 8'h00);
        check("R8 pass-through byte", rx[7:0], 8'h96);
        check("R8 last byte latched", ctrl, 8'h5A);

        // R2 R4: all channels on, sense all high
        sense = 8'hFF;
        select();
        for (int i = 7; i >= 0; i--) begin xfer_bit(1'b0, r); rx[i] = r; end
        deselect();
        check("R2 sense all high", rx[7:0], 8'hFF);
        check("R4 all channels on", ctrl, 8'h00);

        // R1: reset again restores off state
        rst = 1'b1; wait_clk(2); rst = 1'b0; wait_clk(2);
        check("R1 ctrl after second reset", ctrl, 8'hFF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule